// File: doc/BRIEF.md
# Clock Synthesizer Parameter Register Bank

This block holds the divider settings for two clock synthesizers behind a small byte-wide host port. An 8-bit index register, reachable through two register codes, picks one of sixteen entries, and a single data code moves bytes to and from the indexed entry. Most entries are a feedback byte (M) followed by a divider byte (N). One entry is a single-byte control register. After each complete entry access the index moves on by itself, so the host can stream a whole table without rewriting the index.

Entries 0 to 7 are the eight video clock choices. Entry 10 is the memory clock. The video choice comes from three external select pins, unless the control register switches selection to its own bits. The block drives the M and N words of the selected video entry and of the memory entry. It raises a one-cycle pulse when a live setting is replaced. The synthesizers themselves are outside this block.

Top module: `ckp_bank`

## Requirements
- R1: An access with `reg_sel_i` = 0 or 3 reaches the index register. A write keeps `wdata_i[3:0]`, and a read returns the index in bits 3:0 with bits 7:4 reading 0. Both codes address the same register. Code 2 reads 0 and writes nothing.
- R2: Data accesses (`reg_sel_i` = 1) to a two-byte entry go first to M (byte 0) and then to N (byte 1). The index advances by one after the N access, whether it is a read or a write.
- R3: Index 14 is a single-byte control register, and the index advances after every access to it. Only bits 5 and 2:0 are kept, and the other bits read 0.
- R4: The index wraps from 15 to 0 when it advances.
- R5: Entries 0 and 1 are read-only. Writes to them are ignored, but the byte walk still advances.
- R6: Indices 8, 9, 11, 12, 13 and 15 are reserved. They read 0 and ignore writes.
- R7: Entries 2 to 7 and 10 are writable and keep bits 6:0 of each byte. Bit 7 always reads 0.
- R8: A written entry changes only on its N write. After the M write alone, the stored entry and all clock outputs are unchanged.
- R9: When control bit 5 is 1, `vclk_sel_o` equals control bits 2:0 and `ext_sel_i` is ignored. When it is 0, `vclk_sel_o` follows `ext_sel_i`. `vclk_m_o`/`vclk_n_o` carry the entry that is selected.
- R10: `mclk_m_o`/`mclk_n_o` carry entry 10.
- R11: `upd_o` is high for exactly the one cycle after an N write that commits the currently selected video entry or entry 10. No other event raises it.
- R12: Writing the index returns the byte walk to M.
- R13: After reset the index is 0 and the control register is 0. Entry i holds M = 48 + 5·i and N = 32·(i mod 4) + i + 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 2 | 0/3 index, 1 data, 2 unused |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte for the current access |
| ext_sel_i | input | 3 | External video clock select |
| vclk_sel_o | output | 3 | Active video entry |
| vclk_m_o | output | 7 | Video feedback value |
| vclk_n_o | output | 7 | Video divider byte (post code 6:5, prescale 4:0) |
| mclk_m_o | output | 7 | Memory clock feedback value |
| mclk_n_o | output | 7 | Memory clock divider byte |
| upd_o | output | 1 | Pulse: live setting replaced |

## Verification
The bench uses the default build, in which two video entries are read-only. This makes the fixed-entry boundary at index 1/2 observable, along with the reserved holes around the memory entry and the single-byte control slot next to the wrap point at 15. Within those settings it checks split M/N commits, pointer reset by index writes, and the hand-over of select authority between pins and control bits.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
  localparam int IDX_W    = 4;
  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int VID_NUM  = 8;
  localparam int SEL_W    = 3;
  localparam int PW       = 7;
  localparam int CTRL_IDX = 14;
  localparam int MEM_IDX  = 10;
  localparam logic [7:0] CTRL_MASK = 8'h27;
  localparam int CTRL_INT_BIT = 5;

  typedef enum logic [1:0] {
    RS_IDX_A = 2'b00,
    RS_DATA  = 2'b01,
    RS_NONE  = 2'b10,
    RS_IDX_B = 2'b11
  } reg_sel_e;

  function automatic logic [PW-1:0] dflt_m(int i);
    return PW'(48 + 5 * i);
  endfunction

  function automatic logic [PW-1:0] dflt_n(int i);
    return PW'((i % 4) * 32 + i + 3);
  endfunction

  function automatic bit is_rw(int i, int nfixed);
    return ((i >= nfixed) && (i < VID_NUM)) || (i == MEM_IDX);
  endfunction

  function automatic bit is_fixed(int i, int nfixed);
    return i < nfixed;
  endfunction
endpackage

// File: rtl/ckp_host.sv
module ckp_host
  import ckp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             ptr_o,
  output logic             data_wr_o,
  output logic             data_rd_o,
  output logic             idx_sel_o
);
  logic [IDX_W-1:0] idx_q;
  logic             ptr_q;
  logic             data_hit;
  logic             last_byte;

  assign idx_sel_o = (reg_sel_i == RS_IDX_A) || (reg_sel_i == RS_IDX_B);
  assign data_hit  = cs_i && (reg_sel_i == RS_DATA);
  assign data_wr_o = data_hit && we_i;
  assign data_rd_o = data_hit && !we_i;
  assign last_byte = (idx_q == IDX_W'(CTRL_IDX)) || ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ptr_q <= 1'b0;
    end else if (cs_i && we_i && idx_sel_o) begin
      idx_q <= wdata_i[IDX_W-1:0];
      ptr_q <= 1'b0;
    end else if (data_hit) begin
      if (last_byte) begin
        idx_q <= idx_q + 1'b1;  // wraps at NUM_IDX
        ptr_q <= 1'b0;
      end else begin
        ptr_q <= 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/ckp_store.sv
module ckp_store
  import ckp_pkg::*;
#(
  parameter int NUM_FIXED = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         data_wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic                         ptr_i,
  input  logic [7:0]                   wdata_i,
  input  logic [SEL_W-1:0]             vsel_i,
  output logic [NUM_IDX-1:0][PW-1:0]   m_o,
  output logic [NUM_IDX-1:0][PW-1:0]   n_o,
  output logic [7:0]                   ctrl_o,
  output logic                         upd_o
);
  logic [PW-1:0] stage_q;
  logic [7:0]    ctrl_q;
  logic          upd_q;
  logic          is_ctrl;
  logic          commit;
  logic          live_hit;

  assign is_ctrl  = (idx_i == IDX_W'(CTRL_IDX));
  assign commit   = data_wr_i && ptr_i && !is_ctrl && is_rw(int'(idx_i), NUM_FIXED);
  assign live_hit = (idx_i == IDX_W'(vsel_i)) || (idx_i == IDX_W'(MEM_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (data_wr_i && !ptr_i && !is_ctrl) begin
      stage_q <= wdata_i[PW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (data_wr_i && is_ctrl) begin
      ctrl_q <= wdata_i & CTRL_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= commit && live_hit;
  end

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_ent
    if (is_fixed(i, NUM_FIXED)) begin : g_fix
      assign m_o[i] = dflt_m(i);
      assign n_o[i] = dflt_n(i);
    end else if (is_rw(i, NUM_FIXED)) begin : g_rw
      logic [PW-1:0] m_q, n_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          m_q <= dflt_m(i);
          n_q <= dflt_n(i);
        end else if (commit && (idx_i == IDX_W'(i))) begin
          m_q <= stage_q;
          n_q <= wdata_i[PW-1:0];
        end
      end
      assign m_o[i] = m_q;
      assign n_o[i] = n_q;
    end else begin : g_rsv
      assign m_o[i] = '0;
      assign n_o[i] = '0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/ckp_sel.sv
module ckp_sel
  import ckp_pkg::*;
(
  input  logic [7:0]                 ctrl_i,
  input  logic [SEL_W-1:0]           ext_sel_i,
  input  logic [NUM_IDX-1:0][PW-1:0] m_i,
  input  logic [NUM_IDX-1:0][PW-1:0] n_i,
  output logic [SEL_W-1:0]           vsel_o,
  output logic [PW-1:0]              vm_o,
  output logic [PW-1:0]              vn_o,
  output logic [PW-1:0]              mm_o,
  output logic [PW-1:0]              mn_o
);
  assign vsel_o = ctrl_i[CTRL_INT_BIT] ? ctrl_i[SEL_W-1:0] : ext_sel_i;
  assign vm_o   = m_i[vsel_o];
  assign vn_o   = n_i[vsel_o];
  assign mm_o   = m_i[MEM_IDX];
  assign mn_o   = n_i[MEM_IDX];
endmodule

// File: rtl/ckp_bank.sv
module ckp_bank
  import ckp_pkg::*;
#(
  parameter int NUM_FIXED = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [2:0]  ext_sel_i,
  output logic [2:0]  vclk_sel_o,
  output logic [6:0]  vclk_m_o,
  output logic [6:0]  vclk_n_o,
  output logic [6:0]  mclk_m_o,
  output logic [6:0]  mclk_n_o,
  output logic        upd_o
);
  logic [IDX_W-1:0]           idx;
  logic                       ptr;
  logic                       data_wr, data_rd, idx_sel;
  logic [NUM_IDX-1:0][PW-1:0] m_all, n_all;
  logic [7:0]                 ctrl_q;
  logic [SEL_W-1:0]           vsel;

  ckp_host u_host (
    .clk_i, .rst_ni, .cs_i, .we_i, .reg_sel_i, .wdata_i,
    .idx_o(idx), .ptr_o(ptr), .data_wr_o(data_wr), .data_rd_o(data_rd),
    .idx_sel_o(idx_sel)
  );

  ckp_store #(.NUM_FIXED(NUM_FIXED)) u_store (
    .clk_i, .rst_ni, .data_wr_i(data_wr), .idx_i(idx), .ptr_i(ptr),
    .wdata_i, .vsel_i(vsel), .m_o(m_all), .n_o(n_all), .ctrl_o(ctrl_q),
    .upd_o
  );

  ckp_sel u_sel (
    .ctrl_i(ctrl_q), .ext_sel_i, .m_i(m_all), .n_i(n_all),
    .vsel_o(vsel), .vm_o(vclk_m_o), .vn_o(vclk_n_o),
    .mm_o(mclk_m_o), .mn_o(mclk_n_o)
  );

  assign vclk_sel_o = vsel;

  always_comb begin
    rdata_o = '0;
    if (idx_sel) begin
      rdata_o = 8'(idx);
    end else if (reg_sel_i == RS_DATA) begin
      if (idx == IDX_W'(CTRL_IDX)) rdata_o = ctrl_q;
      else if (ptr)                rdata_o = {1'b0, n_all[idx]};
      else                         rdata_o = {1'b0, m_all[idx]};
    end
  end
endmodule

// File: rtl/ckp_bank_chk.sv
module ckp_bank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       we_i,
  input logic [1:0] reg_sel_i,
  input logic [7:0] rdata_o,
  input logic [2:0] ext_sel_i,
  input logic [2:0] vclk_sel_o,
  input logic [6:0] vclk_m_o,
  input logic [6:0] vclk_n_o,
  input logic       upd_o,
  input logic [7:0] ctrl_i
);
  logic past_ok;
  logic wr_data;
  assign wr_data = cs_i && we_i && (reg_sel_i == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_idx_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (reg_sel_i == 2'b00 || reg_sel_i == 2'b11)) |-> (rdata_o[7:4] == 4'h0));

  a_r3_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i & 8'hD8) == 8'h00);

  a_r7_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && reg_sel_i == 2'b01 && ctrl_i != 8'hFF) |-> !rdata_o[7]);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(wr_data) && $stable(vclk_sel_o))
      |-> ($stable(vclk_m_o) && $stable(vclk_n_o)));

  a_r9_int_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[5] |-> (vclk_sel_o == ctrl_i[2:0]));

  a_r9_ext_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[5] |-> (vclk_sel_o == ext_sel_i));

  a_r11_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  a_r11_upd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (past_ok && $past(wr_data)));
endmodule

bind ckp_bank ckp_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
  .reg_sel_i(reg_sel_i), .rdata_o(rdata_o), .ext_sel_i(ext_sel_i),
  .vclk_sel_o(vclk_sel_o), .vclk_m_o(vclk_m_o), .vclk_n_o(vclk_n_o),
  .upd_o(upd_o), .ctrl_i(ctrl_q)
);

// File: tb/sim_ckp_bank.sv
module sim_ckp_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] rs = 2'b00;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic [2:0] ext = 3'd0;
  logic [2:0] vsel;
  logic [6:0] vm, vn, mm, mn;
  logic       upd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ckp_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .reg_sel_i(rs),
    .wdata_i(wd), .rdata_o(rdata), .ext_sel_i(ext), .vclk_sel_o(vsel),
    .vclk_m_o(vm), .vclk_n_o(vn), .mclk_m_o(mm), .mclk_n_o(mn), .upd_o(upd)
  );

  function automatic int em(int i); return 48 + 5 * i; endfunction
  function automatic int en(int i); return (i % 4) * 32 + i + 3; endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] s, input logic w, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    cs = 1'b1; we = w; rs = s; wd = d;
    #2 q = rdata;
    @(posedge clk);
    #1 cs = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    logic [7:0] q;
    bus(s, 1'b1, d, q);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] q);
    bus(s, 1'b0, 8'h00, q);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    check("R13 vclk_m", vm, em(0));
    check("R13 vclk_n", vn, en(0));
    check("R13 mclk_m", mm, em(10));
    check("R13 mclk_n", mn, en(10));
    check("R13 upd", upd, 0);
    rd(2'b00, q); check("R13 index", q, 0);
  endtask

  task automatic t_index();
    logic [7:0] q;
    wr(2'b00, 8'hA5); rd(2'b11, q); check("R1 alias B", q, 8'h05);
    wr(2'b11, 8'h37); rd(2'b00, q); check("R1 alias A", q, 8'h07);
    wr(2'b10, 8'h09); rd(2'b10, q); check("R1 code2 read", q, 0);
    rd(2'b00, q); check("R1 code2 no write", q, 8'h07);
  endtask

  task automatic t_defaults();
    logic [7:0] q;
    wr(2'b00, 8'd6);
    rd(2'b01, q); check("R13 m6", q, em(6));
    rd(2'b01, q); check("R13 n6", q, en(6));
    rd(2'b00, q); check("R2 advance", q, 7);
  endtask

  task automatic t_two_byte();
    logic [7:0] q;
    ext = 3'd3;
    #1 check("R9 ext sel", vsel, 3);
    wr(2'b00, 8'd3);
    wr(2'b01, 8'h91);
    check("R8 m held", vm, em(3));
    check("R8 upd low", upd, 0);
    wr(2'b01, 8'hE2);
    check("R11 upd pulse", upd, 1);
    check("R8 m new", vm, 8'h11);
    check("R8 n new", vn, 8'h62);
    @(posedge clk); #1 check("R11 upd one cycle", upd, 0);
    wr(2'b00, 8'd3);
    rd(2'b01, q); check("R7 m readback", q, 8'h11);
    rd(2'b01, q); check("R7 n readback", q, 8'h62);
    rd(2'b00, q); check("R2 index 4", q, 4);
  endtask

  task automatic t_ptr();
    logic [7:0] q;
    wr(2'b00, 8'd4); wr(2'b01, 8'h0A);
    wr(2'b00, 8'd4); wr(2'b01, 8'h0B); wr(2'b01, 8'h0C);
    wr(2'b00, 8'd4);
    rd(2'b01, q); check("R12 m", q, 8'h0B);
    rd(2'b01, q); check("R12 n", q, 8'h0C);
  endtask

  task automatic t_fixed();
    logic [7:0] q;
    wr(2'b00, 8'd1); wr(2'b01, 8'h55); wr(2'b01, 8'h66);
    rd(2'b00, q); check("R5 walk advances", q, 2);
    wr(2'b00, 8'd1);
    rd(2'b01, q); check("R5 m fixed", q, em(1));
    rd(2'b01, q); check("R5 n fixed", q, en(1));
  endtask

  task automatic t_reserved();
    logic [7:0] q;
    wr(2'b00, 8'd9); wr(2'b01, 8'h12); wr(2'b01, 8'h34);
    wr(2'b00, 8'd9);
    rd(2'b01, q); check("R6 m zero", q, 0);
    rd(2'b01, q); check("R6 n zero", q, 0);
    wr(2'b00, 8'd15); wr(2'b01, 8'h7F);
    wr(2'b00, 8'd15);
    rd(2'b01, q); check("R6 idx15 m", q, 0);
    rd(2'b01, q); check("R6 idx15 n", q, 0);
    rd(2'b00, q); check("R4 wrap", q, 0);
  endtask

  task automatic t_mem();
    wr(2'b00, 8'd10); wr(2'b01, 8'h40); wr(2'b01, 8'h21);
    check("R11 upd mem", upd, 1);
    check("R10 mclk_m", mm, 8'h40);
    check("R10 mclk_n", mn, 8'h21);
  endtask

  task automatic t_noupd();
    wr(2'b00, 8'd5); wr(2'b01, 8'h33); wr(2'b01, 8'h44);
    check("R11 no upd unselected", upd, 0);
    check("R9 vclk unchanged", vm, 8'h11);
  endtask

  task automatic t_ctrl();
    logic [7:0] q;
    wr(2'b00, 8'd14); wr(2'b01, 8'hFD);
    rd(2'b00, q); check("R3 single byte advance", q, 15);
    wr(2'b00, 8'd14); rd(2'b01, q); check("R3 ctrl mask", q, 8'h25);
    rd(2'b00, q); check("R3 read advance", q, 15);
    check("R9 int sel", vsel, 5);
    check("R9 int m", vm, 8'h33);
    check("R9 int n", vn, 8'h44);
    ext = 3'd6;
    #1 check("R9 pins ignored", vsel, 5);
    wr(2'b00, 8'd14); wr(2'b01, 8'h00);
    check("R9 back to pins", vsel, 6);
    check("R9 pins m", vm, em(6));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_index();
    t_defaults();
    t_two_byte();
    t_ptr();
    t_fixed();
    t_reserved();
    t_mem();
    t_noupd();
    t_ctrl();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule